// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder

This block sits between a small microcontroller and the devices on its shared address/data bus. The controller first places the low address byte on the eight shared lines and raises the address strobe. The block captures that byte, along with the upper address bits and the data-memory qualifier, into a holding register. It then presents the captured low byte as a static address while the shared lines carry data. From the held values it produces one active-low select for program memory, one for calibration memory, and a vector of active-low peripheral selects.

The decode is layered. The held data-memory qualifier chooses between program space (qualifier 0) and data space (qualifier 1). In data space the top upper-address bit (A11) chooses calibration memory (1) or the peripheral group (0). In the peripheral group the three bits below it (A10..A8) form a code. Only codes 0, 3, 4, 5 and 7 drive a select. Peripheral selects are also gated by the data strobe.

A three-state cycle tracker, clocked by the system clock, follows each bus cycle. IDLE means no address has been held since the last cycle ended. ADDR is entered on any clock edge that sees the address strobe high; the address has been captured and the tracker waits for data. DATA is entered from ADDR when the address strobe is low and the data strobe is high. The transitions are named as follows. `start` takes IDLE to ADDR on the address strobe. `recapture` takes ADDR or DATA back to ADDR on the address strobe, and it has priority over every other transition. `data_on` takes ADDR to DATA on the data strobe. `data_off` takes DATA to IDLE when the data strobe falls. `wait` holds ADDR while neither strobe is high. `idle_hold` holds IDLE while the address strobe is low.

Top module: `mbd_addr_decoder`

## Requirements
- R1: On every rising clock edge where `as_i` is 1, the holding register loads `ad_i`, `hi_i` and `dm_i`. `addr_lo_o` shows the new byte right after that edge. On edges where `as_i` is 0, the held values do not change.
- R2: While `rst_n` is 0, `addr_lo_o` is 0, every select output is 1 (inactive), and the tracker is in IDLE.
- R3: The tracker follows the named transitions, with `recapture`/`start` taking priority. Memory selects can be active only in ADDR or DATA. Peripheral selects can be active only in DATA.
- R4: `prog_cs_n_o` is 0 exactly when the tracker is in ADDR or DATA and the held qualifier is 0.
- R5: `cal_cs_n_o` is 0 exactly when the tracker is in ADDR or DATA, the held qualifier is 1, and held `hi_i[3]` is 1.
- R6: `per_cs_n_o[c]` is 0 exactly when all of the following hold: the tracker is in DATA, `ds_i` is 1, the held qualifier is 1, held `hi_i[3]` is 0, held `hi_i[2:0]` equals c, and c is one of 0, 3, 4, 5, 7.
- R7: Held codes 1, 2 and 6 in the peripheral group assert no select at all. Bits 1, 2 and 6 of `per_cs_n_o` stay at 1 at all times.
- R8: In any cycle where `ds_i` is 0, every bit of `per_cs_n_o` is 1, whatever the held address. This holds in the same cycle, with no clock delay.
- R9: At most one of the ten select outputs is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 8 | Shared address/data lines (low address byte during address phase) |
| hi_i | input | 4 | Upper address bits A11..A8 |
| as_i | input | 1 | Address strobe, active high |
| ds_i | input | 1 | Data strobe, active high |
| dm_i | input | 1 | Data-memory qualifier: 0 program space, 1 data space |
| addr_lo_o | output | 8 | Held low address byte |
| prog_cs_n_o | output | 1 | Program memory select, active low |
| cal_cs_n_o | output | 1 | Calibration memory select, active low |
| per_cs_n_o | output | 8 | Peripheral selects indexed by code, active low; bits 1, 2, 6 always 1 |

## Verification
The bench targets several corner cases.

- Both strobes high in one cycle. A design that let data outrank the address strobe would keep a stale peripheral selected across a new address.
- The data strobe falling in DATA. A design that registered the gate would leave a peripheral select low for one extra cycle.
- A sweep of all eight codes. A decoder off by one code, or one that decodes the full code set, would assert a select on an unused code.
- Address changes on the shared lines after capture. A latch left transparent would let the data byte leak onto the held address.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_ADDR = 2'd1,
        CYC_DATA = 2'd2
    } cyc_state_t;

endpackage

// File: rtl/mbd_addr_hold.sv
module mbd_addr_hold #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (cap_i) begin
            q_o <= d_i;
        end
    end

    // R1: a strobe edge loads the bus value
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (q_o == $past(d_i)));

    // R1: without a strobe the held value does not move
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(q_o));

endmodule

// File: rtl/mbd_cycle_fsm.sv
module mbd_cycle_fsm
    import mbd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_i,
    input  logic ds_i,
    output logic addr_valid_o,
    output logic data_phase_o
);

    cyc_state_t state_q;
    cyc_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (as_i) begin
            state_d = CYC_ADDR;               // start / recapture
        end else begin
            unique case (state_q)
                CYC_IDLE: state_d = CYC_IDLE;                     // idle_hold
                CYC_ADDR: state_d = ds_i ? CYC_DATA : CYC_ADDR;   // data_on / wait
                CYC_DATA: state_d = ds_i ? CYC_DATA : CYC_IDLE;   // stay / data_off
                default:  state_d = CYC_IDLE;
            endcase
        end
    end

    always_comb begin
        addr_valid_o = 1'b0;
        data_phase_o = 1'b0;
        unique case (state_q)
            CYC_IDLE: ;
            CYC_ADDR: addr_valid_o = 1'b1;
            CYC_DATA: begin
                addr_valid_o = 1'b1;
                data_phase_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R3: DATA is never entered straight from IDLE
    p_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CYC_IDLE) |=> (state_q != CYC_DATA));

    // R3: address strobe always lands in ADDR
    p_recapture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        as_i |=> (state_q == CYC_ADDR));

endmodule

// File: rtl/mbd_sel_decode.sv
module mbd_sel_decode #(
    parameter int                          HI_W        = 4,
    parameter logic [(1<<(HI_W-1))-1:0]    PERIPH_MASK = 8'hB9
) (
    input  logic                         addr_valid_i,
    input  logic                         data_phase_i,
    input  logic                         ds_i,
    input  logic                         dm_i,
    input  logic [HI_W-1:0]              hi_i,
    output logic                         prog_cs_n_o,
    output logic                         cal_cs_n_o,
    output logic [(1<<(HI_W-1))-1:0]     per_cs_n_o
);

    localparam int CODE_W    = HI_W - 1;
    localparam int NUM_CODES = 1 << CODE_W;

    logic              per_group;
    logic              per_window;
    logic [CODE_W-1:0] code;

    assign code       = hi_i[CODE_W-1:0];
    assign per_group  = dm_i && !hi_i[HI_W-1];
    assign per_window = data_phase_i && ds_i && per_group;

    assign prog_cs_n_o = !(addr_valid_i && !dm_i);
    assign cal_cs_n_o  = !(addr_valid_i && dm_i && hi_i[HI_W-1]);

    for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_code
        if (PERIPH_MASK[gi]) begin : g_used
            assign per_cs_n_o[gi] = !(per_window && (code == CODE_W'(gi)));
        end else begin : g_unused
            assign per_cs_n_o[gi] = 1'b1;
        end
    end

endmodule

// File: rtl/mbd_addr_decoder.sv
module mbd_addr_decoder #(
    parameter int                          AD_W        = 8,
    parameter int                          HI_W        = 4,
    parameter logic [(1<<(HI_W-1))-1:0]    PERIPH_MASK = 8'hB9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [AD_W-1:0]              ad_i,
    input  logic [HI_W-1:0]              hi_i,
    input  logic                         as_i,
    input  logic                         ds_i,
    input  logic                         dm_i,
    output logic [AD_W-1:0]              addr_lo_o,
    output logic                         prog_cs_n_o,
    output logic                         cal_cs_n_o,
    output logic [(1<<(HI_W-1))-1:0]     per_cs_n_o
);

    localparam int NUM_CODES = 1 << (HI_W - 1);
    localparam int HOLD_W    = 1 + HI_W + AD_W;

    logic [HOLD_W-1:0] held;
    logic [HI_W-1:0]   held_hi;
    logic              held_dm;
    logic              addr_valid;
    logic              data_phase;

    mbd_addr_hold #(.W(HOLD_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (as_i),
        .d_i   ({dm_i, hi_i, ad_i}),
        .q_o   (held)
    );

    assign held_dm   = held[HOLD_W-1];
    assign held_hi   = held[AD_W +: HI_W];
    assign addr_lo_o = held[AD_W-1:0];

    mbd_cycle_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .as_i         (as_i),
        .ds_i         (ds_i),
        .addr_valid_o (addr_valid),
        .data_phase_o (data_phase)
    );

    mbd_sel_decode #(.HI_W(HI_W), .PERIPH_MASK(PERIPH_MASK)) u_dec (
        .addr_valid_i (addr_valid),
        .data_phase_i (data_phase),
        .ds_i         (ds_i),
        .dm_i         (held_dm),
        .hi_i         (held_hi),
        .prog_cs_n_o  (prog_cs_n_o),
        .cal_cs_n_o   (cal_cs_n_o),
        .per_cs_n_o   (per_cs_n_o)
    );

    // R8: no peripheral select without the data strobe
    p_ds_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_i |-> (&per_cs_n_o));

    // R9: selects are mutually exclusive
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~{prog_cs_n_o, cal_cs_n_o, per_cs_n_o}) <= 1);

    // R4: program select only for held program-space cycles
    p_prog_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_cs_n_o |-> (!held_dm && addr_valid));

    // R5: calibration select only for held data space with A11 set
    p_cal_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_cs_n_o |-> (held_dm && held_hi[HI_W-1]));

    // R3: a peripheral select implies the data phase of a cycle
    p_per_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (~&per_cs_n_o) |-> data_phase);

    for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_chk
        if (!PERIPH_MASK[gi]) begin : g_unused
            // R7: unused codes stay inactive
            p_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
                per_cs_n_o[gi]);
        end
    end

endmodule

// File: tb/mbd_addr_decoder_bench.sv
module mbd_addr_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] MASK = 8'hB9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ad_i = '0;
    logic [3:0] hi_i = '0;
    logic       as_i = 1'b0;
    logic       ds_i = 1'b0;
    logic       dm_i = 1'b0;
    logic [7:0] addr_lo_o;
    logic       prog_cs_n_o;
    logic       cal_cs_n_o;
    logic [7:0] per_cs_n_o;

    int n_checks = 0;
    int n_errors = 0;

    // reference model state: 0 idle, 1 addr, 2 data
    int         m_st = 0;
    logic [7:0] m_ad = '0;
    logic [3:0] m_hi = '0;
    logic       m_dm = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbd_addr_decoder u_mbd_addr_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .ad_i        (ad_i),
        .hi_i        (hi_i),
        .as_i        (as_i),
        .ds_i        (ds_i),
        .dm_i        (dm_i),
        .addr_lo_o   (addr_lo_o),
        .prog_cs_n_o (prog_cs_n_o),
        .cal_cs_n_o  (cal_cs_n_o),
        .per_cs_n_o  (per_cs_n_o)
    );

    function automatic logic exp_prog();
        return !((m_st != 0) && !m_dm);
    endfunction

    function automatic logic exp_cal();
        return !((m_st != 0) && m_dm && m_hi[3]);
    endfunction

    function automatic logic [7:0] exp_per(input logic ds);
        logic [7:0] v = 8'hFF;
        if (m_st == 2 && ds && m_dm && !m_hi[3] && MASK[m_hi[2:0]])
            v[m_hi[2:0]] = 1'b0;
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [9:0] all_n;
        check("R1 held address", 32'(addr_lo_o), 32'(m_ad));
        check("R4 program select", 32'(prog_cs_n_o), 32'(exp_prog()));
        check("R5 calibration select", 32'(cal_cs_n_o), 32'(exp_cal()));
        check("R6 peripheral selects", 32'(per_cs_n_o), 32'(exp_per(ds_i)));
        all_n = {prog_cs_n_o, cal_cs_n_o, per_cs_n_o};
        check("R9 at most one select", 32'($countones(~all_n) <= 1), 32'd1);
        check("R7 unused codes idle", 32'({per_cs_n_o[6], per_cs_n_o[2], per_cs_n_o[1]}), 32'h7);
        if (!ds_i) check("R8 no strobe no peripheral", 32'(per_cs_n_o), 32'hFF);
    endtask

    task automatic step(input logic as, input logic ds, input logic dm,
                        input logic [7:0] ad, input logic [3:0] hi);
        @(negedge clk);
        as_i = as; ds_i = ds; dm_i = dm; ad_i = ad; hi_i = hi;
        #1;
        check_all();
        @(posedge clk);
        if (as) begin
            m_st = 1; m_ad = ad; m_hi = hi; m_dm = dm;   // R3 start/recapture
        end else if (m_st == 1) begin
            m_st = ds ? 2 : 1;
        end else if (m_st == 2) begin
            m_st = ds ? 2 : 0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R2: reset state with bus activity
        as_i = 1'b1; ds_i = 1'b1; dm_i = 1'b1; ad_i = 8'hA5; hi_i = 4'h3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 reset address", 32'(addr_lo_o), 32'h0);
        check("R2 reset selects", 32'({prog_cs_n_o, cal_cs_n_o, per_cs_n_o}), 32'h3FF);
        as_i = 1'b0; ds_i = 1'b0;
        #1;
        check("R2 idle after reset", 32'({prog_cs_n_o, cal_cs_n_o, per_cs_n_o}), 32'h3FF);
        rst_n = 1'b1;

        // R3 idle_hold: data strobe without an address selects nothing
        step(0, 1, 1, 8'h11, 4'h0);
        // R1/R6: full peripheral cycle on code 3, bus changes after capture
        step(1, 0, 1, 8'h5A, 4'h3);
        step(0, 0, 1, 8'hC3, 4'h0);   // R8 in ADDR with ds low
        step(0, 1, 1, 8'hC3, 4'h0);   // data_on
        step(0, 1, 1, 8'h77, 4'h0);   // DATA, select low
        step(0, 0, 1, 8'h77, 4'h0);   // R8 immediate drop, data_off
        step(0, 0, 1, 8'h77, 4'h0);   // back in IDLE
        // R6/R7: sweep all codes
        for (int c = 0; c < 8; c++) begin
            step(1, 0, 1, 8'(c * 17), 4'(c));
            step(0, 1, 1, 8'hFF, 4'h0);
            step(0, 1, 1, 8'hFF, 4'h0);
            step(0, 0, 1, 8'h00, 4'h0);
        end
        // R5 calibration and R4 program cycles
        step(1, 0, 1, 8'h3C, 4'h8);
        step(0, 1, 1, 8'h00, 4'h0);
        step(0, 0, 1, 8'h00, 4'h0);
        step(1, 0, 0, 8'hE1, 4'h5);
        step(0, 1, 0, 8'h00, 4'h0);
        step(0, 0, 0, 8'h00, 4'h0);
        // R3: both strobes high — recapture wins over data
        step(1, 0, 1, 8'h10, 4'h4);
        step(0, 1, 1, 8'h00, 4'h0);
        step(1, 1, 1, 8'h20, 4'h7);
        step(1, 1, 1, 8'h30, 4'h5);
        step(0, 1, 1, 8'h00, 4'h0);
        step(0, 1, 1, 8'h00, 4'h0);
        step(0, 0, 1, 8'h00, 4'h0);
        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic as_r, ds_r;
            as_r = ($urandom_range(0, 3) == 0);
            ds_r = ($urandom_range(0, 1) == 1);
            step(as_r, ds_r, 1'($urandom), 8'($urandom), 4'($urandom));
        end
        step(0, 0, 0, 8'h00, 4'h0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule